// File: doc/BRIEF.md
# Serial Controller Register Bank with Interrupt Identification

This block is the host-facing register file of a 16550-compatible serial controller. A host reaches it over a byte-wide bus with a 3-bit offset and separate read and write strobes. It holds the configuration of the serial datapath: interrupt enables, line format, FIFO mode and trigger level, modem control outputs and the 16-bit baud divisor. It passes that configuration to the shifters, FIFOs and baud counter, which sit outside this block.

In the other direction it gathers the datapath's status flags. It keeps the receive error flags until software reads them, and it tracks the transmitter-empty event. From these it builds a line status byte and a prioritised interrupt identity code. One interrupt line goes high when an enabled source is pending and the modem-control master gate is on. Bit 7 of the line-control register switches offsets 0 and 1 over to the divisor bytes.

Top module: `uart_regbank`

## Requirements
- R1: With line-control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. Writes go to the `divisor` output, and no transmit load occurs. With bit 7 clear, offsets 0 and 1 reach the data and interrupt-enable registers.
- R2: A write to offset 1 stores bits 3:0 as the interrupt enables (0 rx data, 1 tx empty, 2 line status, 3 modem). A read returns them in bits 3:0 with bits 7:4 zero.
- R3: Reading offset 2 gives bit 0 = 1 when nothing is pending, else 0. Bits 2:1 give the source: 11 line status, 10 rx data, 01 tx empty, 00 modem. Bits 5:3 read 0. After reset it reads 0x01.
- R4: A source counts only when its enable bit is set. When several are pending, the reported source is line status first, then rx data, then tx empty, then modem.
- R5: Offset-2 read bits 7:6 are 11 while the FIFO-enable bit is set and 00 otherwise.
- R6: A write to offset 2 sets FIFO enable from bit 0 and DMA mode from bit 3, and the rx trigger code from bits 7:6 (on `rx_trig`). Bits 1 and 2 raise `rx_fifo_clr` and `tx_fifo_clr` during that write cycle only.
- R7: Offset 5 reads {fifo error, tx idle, tx holding empty, break, framing, parity, overrun, rx ready}, from bit 7 down to bit 0. Error pulses on bits 4:1 are held until an offset-5 read clears them. After reset it reads 0x60 while the transmitter is empty and idle.
- R8: The tx-empty indication is set when `thr_empty` rises, or when enable bit 1 goes from 0 to 1 while `thr_empty` is high. It is cleared by an offset-2 read that reports it, or by a transmit write.
- R9: `irq` is high exactly when some enabled source is pending and modem-control bit 3 is set.
- R10: Line control (8 bits, with parity mode in bits 5:3) and modem control (bits 4:0) read back as written and appear on `lcr_out` and `mcr_out`. Both reset to 0x00.
- R11: A write to offset 0 with bit 7 clear pulses `tx_load` with `tx_byte` equal to the data. A read there returns `rx_byte` and pulses `rx_pop`. A read of offset 6 returns `modem_stat` and pulses `msr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| irq | output | 1 | Interrupt request |
| rx_byte | input | 8 | Head of receive path |
| rx_ready | input | 1 | Receive data available |
| thr_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully empty |
| err_overrun | input | 1 | Overrun pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break pulse |
| fifo_err | input | 1 | Error present in receive FIFO |
| modem_delta | input | 1 | Modem status change pending |
| modem_stat | input | 8 | Modem status byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_load | output | 1 | Transmit load strobe |
| rx_pop | output | 1 | Receive byte consumed |
| msr_rd | output | 1 | Modem status read strobe |
| divisor | output | 16 | Baud divisor |
| lcr_out | output | 8 | Line control |
| mcr_out | output | 5 | Modem control |
| fifo_en | output | 1 | FIFOs enabled |
| dma_mode | output | 1 | DMA mode select |
| rx_trig | output | 2 | Receive trigger code |
| rx_fifo_clr | output | 1 | Clear receive FIFO |
| tx_fifo_clr | output | 1 | Clear transmit FIFO |

## Verification
Read data, the access strobes (`tx_load`, `rx_pop`, `msr_rd` and the FIFO clears) and `irq` are combinational. Reads and strobes are valid in the access cycle. `irq` follows any change of a status input at once. Register writes, sticky-error updates and tx-empty set/clear take effect at the clock edge that ends the access, so their results are due one cycle later. The bench drives each access just after a rising edge and samples read data and strobes a little later in that same cycle. It checks register effects and `irq` just after the following edge.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int IE_W   = 4;
    localparam int MC_W   = 5;
    localparam int ERR_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;

    // source codes reported in identity bits 2:1
    localparam logic [1:0] SRC_LINE = 2'b11;
    localparam logic [1:0] SRC_RX   = 2'b10;
    localparam logic [1:0] SRC_TX   = 2'b01;
    localparam logic [1:0] SRC_MDM  = 2'b00;

    typedef struct packed {
        logic wr_thr;
        logic wr_dlo;
        logic wr_dhi;
        logic wr_ien;
        logic wr_fctl;
        logic wr_line;
        logic wr_modem;
        logic rd_rbuf;
        logic rd_ident;
        logic rd_lstat;
        logic rd_mstat;
    } strobes_t;

    typedef struct packed {
        logic [IE_W-1:0]   ien;
        logic [BYTE_W-1:0] line;
        logic [MC_W-1:0]   modem;
        logic [BYTE_W-1:0] dlo;
        logic [BYTE_W-1:0] dhi;
        logic              fifo_on;
        logic              dma;
        logic [1:0]        trig;
        logic [ERR_W-1:0]  err;
        logic              tx_ev;
        logic              thr_prev;
    } regs_t;
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank_div,
    input  logic              wr_en,
    input  logic              rd_en,
    output strobes_t          st
);
    logic is_data, is_ien;

    always_comb begin
        is_data     = (addr == OFS_DATA);
        is_ien      = (addr == OFS_IEN);
        st          = '0;
        st.wr_thr   = wr_en && is_data && !bank_div;
        st.wr_dlo   = wr_en && is_data &&  bank_div;
        st.wr_dhi   = wr_en && is_ien  &&  bank_div;
        st.wr_ien   = wr_en && is_ien  && !bank_div;
        st.wr_fctl  = wr_en && (addr == OFS_IDENT);
        st.wr_line  = wr_en && (addr == OFS_LINE);
        st.wr_modem = wr_en && (addr == OFS_MODEM);
        st.rd_rbuf  = rd_en && is_data && !bank_div;
        st.rd_ident = rd_en && (addr == OFS_IDENT);
        st.rd_lstat = rd_en && (addr == OFS_LSTAT);
        st.rd_mstat = rd_en && (addr == OFS_MSTAT);
    end
endmodule

// File: rtl/uart_regbank_ident.sv
module uart_regbank_ident
    import uart_regbank_pkg::*;
#(
    parameter int NSRC = IE_W
) (
    input  logic [NSRC-1:0] raw,   // index = enable bit position
    input  logic [NSRC-1:0] ien,
    output logic            pend,
    output logic [1:0]      src
);
    // ranking: line status (bit 2), rx (bit 0), tx (bit 1), modem (bit 3)
    localparam int RANK [4] = '{2, 0, 1, 3};
    localparam logic [1:0] CODE [4] = '{SRC_LINE, SRC_RX, SRC_TX, SRC_MDM};

    logic [NSRC-1:0] live;

    always_comb begin
        live = raw & ien;
        pend = 1'b0;
        src  = SRC_MDM;
        for (int k = 3; k >= 0; k--) begin
            if (live[RANK[k]]) begin
                pend = 1'b1;
                src  = CODE[k];
            end
        end
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_ready,
    input  logic              thr_empty,
    input  logic              tx_idle,
    input  logic              err_overrun,
    input  logic              err_parity,
    input  logic              err_framing,
    input  logic              err_break,
    input  logic              fifo_err,
    input  logic              modem_delta,
    input  logic [BYTE_W-1:0] modem_stat,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_load,
    output logic              rx_pop,
    output logic              msr_rd,
    output logic [2*BYTE_W-1:0] divisor,
    output logic [BYTE_W-1:0] lcr_out,
    output logic [MC_W-1:0]   mcr_out,
    output logic              fifo_en,
    output logic              dma_mode,
    output logic [1:0]        rx_trig,
    output logic              rx_fifo_clr,
    output logic              tx_fifo_clr
);
    regs_t    r_q, r_d;
    strobes_t st;
    logic     pend;
    logic [1:0] src;
    logic [IE_W-1:0] raw;

    uart_regbank_decode u_dec (
        .addr     (addr),
        .bank_div (r_q.line[BYTE_W-1]),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .st       (st)
    );

    assign raw = {modem_delta, |r_q.err, r_q.tx_ev, rx_ready};

    uart_regbank_ident #(.NSRC(IE_W)) u_id (
        .raw  (raw),
        .ien  (r_q.ien),
        .pend (pend),
        .src  (src)
    );

    always_comb begin
        r_d          = r_q;
        r_d.thr_prev = thr_empty;
        if (st.wr_ien)   r_d.ien   = wdata[IE_W-1:0];
        if (st.wr_line)  r_d.line  = wdata;
        if (st.wr_modem) r_d.modem = wdata[MC_W-1:0];
        if (st.wr_dlo)   r_d.dlo   = wdata;
        if (st.wr_dhi)   r_d.dhi   = wdata;
        if (st.wr_fctl) begin
            r_d.fifo_on = wdata[0];
            r_d.dma     = wdata[3];
            r_d.trig    = wdata[7:6];
        end
        // sticky receive errors, new pulses win over the clearing read
        if (st.rd_lstat) r_d.err = '0;
        r_d.err = r_d.err | {err_break, err_framing, err_parity, err_overrun};
        // transmitter-empty event
        if (st.wr_thr || (st.rd_ident && pend && src == SRC_TX))
            r_d.tx_ev = 1'b0;
        if (thr_empty && !r_q.thr_prev)
            r_d.tx_ev = 1'b1;
        if (st.wr_ien && wdata[1] && !r_q.ien[1] && thr_empty)
            r_d.tx_ev = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.thr_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_DATA:  rdata = r_q.line[BYTE_W-1] ? r_q.dlo : rx_byte;
            OFS_IEN:   rdata = r_q.line[BYTE_W-1] ? r_q.dhi
                                                   : {{(BYTE_W-IE_W){1'b0}}, r_q.ien};
            OFS_IDENT: rdata = {{2{r_q.fifo_on}}, 3'b000, src, ~pend};
            OFS_LINE:  rdata = r_q.line;
            OFS_MODEM: rdata = {{(BYTE_W-MC_W){1'b0}}, r_q.modem};
            OFS_LSTAT: rdata = {fifo_err, tx_idle, thr_empty, r_q.err, rx_ready};
            OFS_MSTAT: rdata = modem_stat;
            default:   rdata = '0;
        endcase
    end

    assign irq         = pend && r_q.modem[3];
    assign tx_byte     = wdata;
    assign tx_load     = st.wr_thr;
    assign rx_pop      = st.rd_rbuf;
    assign msr_rd      = st.rd_mstat;
    assign divisor     = {r_q.dhi, r_q.dlo};
    assign lcr_out     = r_q.line;
    assign mcr_out     = r_q.modem;
    assign fifo_en     = r_q.fifo_on;
    assign dma_mode    = r_q.dma;
    assign rx_trig     = r_q.trig;
    assign rx_fifo_clr = st.wr_fctl && wdata[1];
    assign tx_fifo_clr = st.wr_fctl && wdata[2];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq,
    input logic       tx_load,
    input logic [15:0] divisor,
    input logic [7:0] lcr_out,
    input logic [4:0] mcr_out,
    input logic       rx_fifo_clr,
    input logic       tx_fifo_clr
);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mcr_out[3]);

    // R1
    load_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !lcr_out[7]);

    // R1
    dlo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && lcr_out[7]) |=> divisor[7:0] == $past(wdata));

    // R6
    fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_clr || tx_fifo_clr) |-> (wr_en && addr == 3'd2));

    // R2
    ien_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd1 && !lcr_out[7]) |-> rdata[7:4] == 4'h0);

    // R3
    ident_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2) |-> rdata[5:3] == 3'b000);
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq         (irq),
    .tx_load     (tx_load),
    .divisor     (divisor),
    .lcr_out     (lcr_out),
    .mcr_out     (mcr_out),
    .rx_fifo_clr (rx_fifo_clr),
    .tx_fifo_clr (tx_fifo_clr)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic [2:0] addr = 0;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] wdata = 0, rdata;
    logic irq;
    logic [7:0] rx_byte = 8'hA5, modem_stat = 8'h3C;
    logic rx_ready = 0, thr_empty = 1, tx_idle = 1;
    logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
    logic fifo_err = 0, modem_delta = 0;
    logic [7:0] tx_byte, lcr_out;
    logic tx_load, rx_pop, msr_rd, fifo_en, dma_mode, rx_fifo_clr, tx_fifo_clr;
    logic [15:0] divisor;
    logic [4:0] mcr_out;
    logic [1:0] rx_trig;

    int checks = 0, errors = 0;
    logic s_load, s_pop, s_msr, s_rclr, s_tclr;
    logic [7:0] s_byte, v;

    always #(CLK_P/2) clk = ~clk;

    uart_regbank u0 (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        #2;
        s_load = tx_load; s_byte = tx_byte; s_rclr = rx_fifo_clr; s_tclr = tx_fifo_clr;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1;
        #2;
        d = rdata; s_pop = rx_pop; s_msr = msr_rd;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic pulse_clk;
        @(posedge clk); #1;
    endtask

    typedef struct packed {
        logic       is_wr;
        logic [2:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd3, 8'h80, 4'd1},  // open divisor bank
        '{1'b1, 3'd0, 8'h34, 4'd1},
        '{1'b1, 3'd1, 8'h12, 4'd1},
        '{1'b0, 3'd0, 8'h34, 4'd1},  // R1
        '{1'b0, 3'd1, 8'h12, 4'd1},
        '{1'b1, 3'd3, 8'h1B, 4'd10}, // 8 bits, 1 stop, even parity
        '{1'b0, 3'd3, 8'h1B, 4'd10}, // R10
        '{1'b1, 3'd1, 8'hFF, 4'd2},
        '{1'b0, 3'd1, 8'h0F, 4'd2},  // R2
        '{1'b0, 3'd0, 8'hA5, 4'd11}, // R11
        '{1'b1, 3'd1, 8'h00, 4'd2},
        '{1'b1, 3'd4, 8'h1F, 4'd10},
        '{1'b0, 3'd4, 8'h1F, 4'd10},
        '{1'b1, 3'd4, 8'h00, 4'd10},
        '{1'b0, 3'd2, 8'h01, 4'd3},  // R3 tx event pending but disabled
        '{1'b1, 3'd2, 8'hC1, 4'd5},
        '{1'b0, 3'd2, 8'hC1, 4'd5},  // R5
        '{1'b0, 3'd5, 8'h60, 4'd7}   // R7
    };

    initial begin
        #(CLK_P*20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic pulse_err(input int which);
        case (which)
            0: err_overrun = 1;
            default: err_parity = 1;
        endcase
        @(posedge clk); #1;
        err_overrun = 0; err_parity = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state (R3, R7, R10, R2, R9)
        check("R9 irq at reset", {15'd0, irq}, 16'd0);
        rd(3'd2, v); check("R3 ident reset", {8'd0, v}, 16'h01);
        rd(3'd5, v); check("R7 lstat reset", {8'd0, v}, 16'h60);
        rd(3'd3, v); check("R10 line reset", {8'd0, v}, 16'h00);
        rd(3'd4, v); check("R10 modem reset", {8'd0, v}, 16'h00);
        rd(3'd1, v); check("R2 ien reset", {8'd0, v}, 16'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) wr(VEC[i].a, VEC[i].d);
            else begin
                rd(VEC[i].a, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), {8'd0, v}, {8'd0, VEC[i].d});
            end
        end

        // R1 divisor output and bank steering
        check("R1 divisor out", divisor, 16'h1234);
        wr(3'd0, 8'h5A);
        check("R11 tx_load", {15'd0, s_load}, 16'd1);
        check("R11 tx_byte", {8'd0, s_byte}, 16'h5A);
        wr(3'd3, 8'h9B);
        wr(3'd0, 8'h77);
        check("R1 no load in bank", {15'd0, s_load}, 16'd0);
        check("R1 divisor low", divisor, 16'h1277);
        wr(3'd3, 8'h1B);

        // R6 FIFO control
        wr(3'd2, 8'hCF);
        check("R6 rx clear", {15'd0, s_rclr}, 16'd1);
        check("R6 tx clear", {15'd0, s_tclr}, 16'd1);
        check("R6 cfg", {11'd0, fifo_en, dma_mode, rx_trig, 1'b0}, {11'd0, 1'b1, 1'b1, 2'b11, 1'b0});
        wr(3'd2, 8'h40);
        check("R6 no clear", {14'd0, s_rclr, s_tclr}, 16'd0);
        check("R6 cfg2", {12'd0, fifo_en, dma_mode, rx_trig}, {12'd0, 1'b0, 1'b0, 2'b01});
        rd(3'd2, v); check("R5 marker off", {8'd0, v}, 16'h01);

        // R7 sticky errors
        pulse_err(1);
        rd(3'd5, v); check("R7 parity held", {8'd0, v}, 16'h64);
        rd(3'd5, v); check("R7 cleared by read", {8'd0, v}, 16'h60);
        fifo_err = 1;
        rd(3'd5, v); check("R7 fifo err bit", {8'd0, v}, 16'hE0);
        fifo_err = 0;

        // R4 priority walk
        wr(3'd1, 8'h0F);
        wr(3'd4, 8'h08);
        rx_ready = 1; modem_delta = 1;
        pulse_err(0);
        check("R9 irq all pending", {15'd0, irq}, 16'd1);
        rd(3'd2, v); check("R4 line first", {8'd0, v}, 16'h06);
        rd(3'd5, v); check("R7 overrun", {8'd0, v}, 16'h63);
        rd(3'd2, v); check("R4 rx next", {8'd0, v}, 16'h04);
        rx_ready = 0;
        rd(3'd2, v); check("R4 tx next", {8'd0, v}, 16'h02);
        rd(3'd2, v); check("R4 modem last", {8'd0, v}, 16'h00);
        modem_delta = 0; #1;
        rd(3'd2, v); check("R3 none left", {8'd0, v}, 16'h01);
        check("R9 irq idle", {15'd0, irq}, 16'd0);

        // R9 gating
        modem_delta = 1; #1;
        check("R9 irq modem", {15'd0, irq}, 16'd1);
        wr(3'd4, 8'h00);
        check("R9 gate off", {15'd0, irq}, 16'd0);
        wr(3'd4, 8'h08);
        check("R9 gate on", {15'd0, irq}, 16'd1);
        wr(3'd1, 8'h07);
        check("R9 enable off", {15'd0, irq}, 16'd0);
        modem_delta = 0;

        // R8 tx-empty event
        check("R8 idle", {15'd0, irq}, 16'd0);
        thr_empty = 0;
        pulse_clk();
        thr_empty = 1;
        pulse_clk();
        check("R8 rise sets", {15'd0, irq}, 16'd1);
        wr(3'd0, 8'h11);
        check("R8 write clears", {15'd0, irq}, 16'd0);

        // R11 read strobes
        rd(3'd0, v);
        check("R11 rx byte", {8'd0, v}, 16'hA5);
        check("R11 rx_pop", {15'd0, s_pop}, 16'd1);
        rd(3'd6, v);
        check("R11 modem stat", {8'd0, v}, 16'h3C);
        check("R11 msr_rd", {15'd0, s_msr}, 16'd1);

        // R10 outputs
        check("R10 lcr_out", {8'd0, lcr_out}, 16'h1B);
        check("R10 mcr_out", {11'd0, mcr_out}, 16'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule